// File: doc/BRIEF.md
# Pipelined SPI ADC Channel Sequencer

This block turns a one-shot "read channel N" request into the right number of SPI frames for a multi-channel ADC whose data path runs two frames behind its configuration. Each frame is full duplex: the block shifts a configuration word out on MOSI and, in the same frame, shifts in a result that belongs to the configuration written two frames earlier. A new configuration affects only the acquisition that starts after the frame that wrote it. The device begins converting when chip-select rises. It returns to acquisition by itself once conversion ends, so chip-select must stay high for the conversion time before the next frame.

The block remembers which channel it last configured. If the request names that same channel, one configuration frame followed by one fetch frame is enough. If the request names any other channel, the block sends the configuration twice and then fetches, so the returned sample was acquired on the requested input. The user side accepts a request only while idle. It holds a busy flag for the whole sequence and raises a one-cycle valid strobe with the masked result.

Top module: `adc_chan_seq`

## Requirements
- R1: Every configuration frame carries the word `CFG_BASE` with bits [CH_OFS+CH_W-1:CH_OFS] replaced by the requested channel number. With the default parameters these are bits [9:7] of a 16-bit word whose bit 15 (the update flag the device needs to accept a configuration) is set.
- R2: SPI signalling is as follows. SCLK idles low and is low whenever chip-select is high. Bits go MSB first, FRAME_W clocks per frame. MOSI changes only at chip-select fall or on a falling SCLK edge, and MISO is captured on the rising SCLK edge.
- R3: The first request after reset, and any request for a channel other than the last configured one, produces exactly three frames: two configuration frames, then one frame with MOSI all zeros.
- R4: A request for the channel that was last configured produces exactly two frames: one configuration frame, then one all-zero frame.
- R5: The returned result equals the low RES_W bits of the word captured from MISO during the last frame of the sequence. Any higher bits are dropped.
- R6: Between the end of one frame and the start of the next, chip-select stays high for at least CONV_CYC clock cycles.
- R7: A request presented while busy is ignored. It starts no frames, does not change the result, and does not change the remembered channel.
- R8: Busy rises the cycle after a request is accepted and stays high through every frame. It falls in the same cycle that the result-valid strobe rises, and that strobe lasts exactly one cycle.
- R9: After reset, chip-select is high, SCLK, MOSI, busy and result-valid are low, and no channel is marked as configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, taken when not busy |
| req_ch | input | CH_W | Channel to read |
| busy | output | 1 | High while a sequence is running |
| res_valid | output | 1 | One-cycle strobe: result is valid |
| res_data | output | RES_W | Sample of the requested channel |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the ADC |
| spi_miso | input | 1 | Serial data from the ADC |

## Verification
The bench attaches a behavioural ADC that returns, two frames late, a value that depends on the channel being acquired, so any sequence that is one frame short hands back the previous channel's value. It alternates channel switches with repeats, and it includes the first request after reset and the extreme channels 0 and 7. A design that always took the short path, or that marked a channel as valid at reset, would return the wrong channel's sample. One that always took the long path would show an extra frame. The model sets garbage bits above the resolution to catch missing masking. A request injected mid-sequence, followed by a repeat of the original channel, shows whether a busy-time request disturbed the result or the remembered channel. Chip-select high time is measured on every gap, against the guard, to catch frames that start before conversion ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CFG_A = 2'd1,
    SQ_CFG_B = 2'd2,
    SQ_FETCH = 2'd3
  } seq_state_t;
endpackage

// File: rtl/conv_guard_timer.sv
module conv_guard_timer #(
  parameter int CONV_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  input  logic start,
  output logic clear
);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (frame_end) begin
      cnt <= CW'(CONV_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign clear = (cnt == '0);

  // A frame may only be requested once the conversion window has run out
  assert_start_clear_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> cnt == '0);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int W   = 16,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  output logic         idle,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BCW = $clog2(W + 1);

  logic           active;
  logic [DCW-1:0] div_cnt;
  logic [BCW-1:0] bit_cnt;
  logic [W-1:0]   tx_sr;
  logic [W-1:0]   rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
          mosi    <= tx_word[W-1];
          tx_sr   <= {tx_word[W-2:0], 1'b0};
        end
      end else if (div_cnt == DCW'(DIV - 1)) begin
        div_cnt <= '0;
        sclk    <= !sclk;
        if (!sclk) begin
          rx_sr <= {rx_sr[W-2:0], miso};
        end else if (bit_cnt == BCW'(W - 1)) begin
          active  <= 1'b0;
          cs_n    <= 1'b1;
          done    <= 1'b1;
          rx_word <= rx_sr;
          mosi    <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          mosi    <= tx_sr[W-1];
          tx_sr   <= {tx_sr[W-2:0], 1'b0};
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign idle = !active;

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int FRAME_W  = 16,
  parameter int RES_W    = 14,
  parameter int CH_OFS   = 7,
  parameter logic [FRAME_W-1:0] CFG_BASE = 16'hA3C5,
  parameter int SCLK_DIV = 2,
  parameter int CONV_CYC = 20,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_ch,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam logic [FRAME_W-1:0] CH_MASK =
    {{(FRAME_W-CH_W){1'b0}}, {CH_W{1'b1}}} << CH_OFS;
  localparam int HCW = $clog2(CONV_CYC + 2);

  seq_state_t         state;
  logic [CH_W-1:0]    ch_q, cur_ch;
  logic               cur_vld, two_cfg, inflight, start;
  logic               eng_idle, eng_done, guard_ok, launch_ok;
  logic [FRAME_W-1:0] rx_word, cfg_word, tx_word;

  assign cfg_word  = (CFG_BASE & ~CH_MASK) |
                     ({{(FRAME_W-CH_W){1'b0}}, ch_q} << CH_OFS);
  assign tx_word   = (state == SQ_FETCH) ? '0 : cfg_word;
  assign launch_ok = eng_idle && guard_ok && !inflight && !start &&
                     (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      ch_q      <= '0;
      cur_ch    <= '0;
      cur_vld   <= 1'b0;
      two_cfg   <= 1'b0;
      inflight  <= 1'b0;
      start     <= 1'b0;
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      start     <= 1'b0;
      res_valid <= 1'b0;
      if (launch_ok) begin
        start    <= 1'b1;
        inflight <= 1'b1;
      end
      unique case (state)
        SQ_IDLE: if (req_valid) begin
          ch_q    <= req_ch;
          two_cfg <= !(cur_vld && cur_ch == req_ch);
          busy    <= 1'b1;
          state   <= SQ_CFG_A;
        end
        SQ_CFG_A: if (eng_done) begin
          inflight <= 1'b0;
          cur_ch   <= ch_q;
          cur_vld  <= 1'b1;
          state    <= two_cfg ? SQ_CFG_B : SQ_FETCH;
        end
        SQ_CFG_B: if (eng_done) begin
          inflight <= 1'b0;
          state    <= SQ_FETCH;
        end
        SQ_FETCH: if (eng_done) begin
          inflight  <= 1'b0;
          res_data  <= rx_word[RES_W-1:0];
          res_valid <= 1'b1;
          busy      <= 1'b0;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  spi_frame_engine #(.W(FRAME_W), .DIV(SCLK_DIV)) u_engine (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
    .miso(spi_miso), .idle(eng_idle), .done(eng_done), .rx_word(rx_word),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  conv_guard_timer #(.CONV_CYC(CONV_CYC)) u_guard (
    .clk(clk), .rst(rst), .frame_end(eng_done), .start(start),
    .clear(guard_ok)
  );

  // Checker counter: cycles chip-select has been high, saturating
  logic [HCW-1:0] hi_q;
  always_ff @(posedge clk) begin
    if (rst)                          hi_q <= HCW'(CONV_CYC);
    else if (!spi_cs_n)               hi_q <= '0;
    else if (hi_q < HCW'(CONV_CYC))   hi_q <= hi_q + 1'b1;
  end

  assert_cs_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> hi_q >= HCW'(CONV_CYC));
  assert_ignore_req_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ch_q));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  assert_busy_release_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);
  assert_cs_busy_R8: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);
endmodule

// File: tb/adc_chan_seq_test.sv
module adc_chan_seq_test;
  localparam int CONV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_ch = '0;
  logic        busy, res_valid, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [13:0] res_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = !clk;

  adc_chan_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ch(req_ch),
    .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  function automatic logic [15:0] cfg_of(input int ch);
    return (16'hA3C5 & ~16'h0380) | (16'(ch & 7) << 7);
  endfunction

  function automatic logic [13:0] val_of(input int ch);
    return 14'(ch * 1000 + 77);
  endfunction

  // Device model: result returned in frame k+1 is converted at the end of
  // frame k from the configuration written in frame k-1
  logic [15:0] m_out, m_in, m_cfg, m_next;
  logic [15:0] words [0:7];
  int nframes = 0;
  int hi_cyc = 0;

  initial begin
    m_cfg  = cfg_of(7);
    m_next = 16'hFFFF;
    m_out  = '0;
    m_in   = '0;
  end

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(negedge spi_cs_n) if (!rst) begin
    m_out    = m_next;
    spi_miso = m_next[15];
    chk(hi_cyc >= CONV, "R6 chip-select high time", hi_cyc, CONV);
  end
  always @(posedge spi_sclk) if (!spi_cs_n) m_in = {m_in[14:0], spi_mosi};
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    m_out    = {m_out[14:0], 1'b0};
    spi_miso = m_out[15];
  end
  always @(posedge spi_cs_n) if (!rst) begin
    if (nframes < 8) words[nframes] = m_in;
    nframes++;
    m_next = {2'b10, val_of(int'(m_cfg[9:7]))};
    if (m_in[15]) m_cfg = m_in;
  end
  always @(posedge clk) begin
    if (rst)           hi_cyc = CONV;
    else if (spi_cs_n) hi_cyc++;
    else               hi_cyc = 0;
  end

  task automatic do_req(input int ch, input int nexp, input bit inject,
                        input string tag);
    int waitc = 0;
    int drops = 0;
    nframes = 0;
    @(negedge clk); req_valid = 1'b1; req_ch = 3'(ch);
    @(negedge clk); req_valid = 1'b0;
    chk(busy, "R8 busy after accept", busy, 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_ch = 3'(ch + 3);
      @(negedge clk); req_valid = 1'b0;
    end
    while (!res_valid && waitc < 5000) begin
      if (!busy) drops++;
      @(negedge clk); waitc++;
    end
    chk(res_valid, "R8 result strobe seen", res_valid, 1);
    chk(drops == 0, "R8 busy held during sequence", drops, 0);
    chk(!busy, "R8 busy drops with strobe", busy, 0);
    chk(res_data == val_of(ch), {tag, " R5 masked result"}, res_data, val_of(ch));
    chk(nframes == nexp, {tag, " frame count"}, nframes, nexp);
    for (int i = 0; i < nexp - 1 && i < 8; i++)
      chk(words[i] == cfg_of(ch), "R1 configuration word", words[i], cfg_of(ch));
    if (nexp >= 1 && nexp <= 8)
      chk(words[nexp-1] == 16'h0, {tag, " zero final frame"}, words[nexp-1], 0);
    @(negedge clk);
    chk(!res_valid, "R8 strobe one cycle", res_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(spi_cs_n, "R9 cs_n high", spi_cs_n, 1);
    chk(!spi_sclk, "R9 sclk low", spi_sclk, 0);
    chk(!spi_mosi, "R9 mosi low", spi_mosi, 0);
    chk(!busy, "R9 busy low", busy, 0);
    chk(!res_valid, "R9 valid low", res_valid, 0);
  endtask

  task automatic t_first;   do_req(3, 3, 1'b0, "R9 R3 first"); endtask
  task automatic t_same;    do_req(3, 2, 1'b0, "R4 repeat");   endtask
  task automatic t_switch;  do_req(6, 3, 1'b0, "R3 switch");   endtask

  task automatic t_busy_ignore;
    do_req(1, 3, 1'b1, "R7 injected");
    nframes = 0;
    repeat (60) @(negedge clk);
    chk(nframes == 0, "R7 no frames after sequence", nframes, 0);
    chk(!busy, "R7 stays idle", busy, 0);
    do_req(1, 2, 1'b0, "R7 channel kept");
  endtask

  task automatic t_extremes;
    do_req(0, 3, 1'b0, "R3 channel 0");
    do_req(7, 3, 1'b0, "R3 channel 7");
    do_req(7, 2, 1'b0, "R4 channel 7");
    do_req(0, 3, 1'b0, "R3 back to 0");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_first();
    t_same();
    t_switch();
    t_busy_ignore();
    t_extremes();
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule